// File: doc/BRIEF.md
# Cursor Generator Host Register Port

This block is the host-facing side of a hardware cursor generator. The host reaches all of the block's storage through four narrow ports that share one 16-bit internal pointer. Two of the ports load the pointer one byte at a time. The third port reads and writes byte-wide control registers. The fourth port reads and writes whole 16-bit words of a 512-word cursor bitmap RAM. Each access through either data port advances the pointer by one. Software therefore sets the pointer once and then streams a run of register or bitmap values.

The block holds the command byte, the cursor position and the crosshair window rectangle, and drives them to the display logic as decoded fields and 12-bit coordinates. A second read-only port on the bitmap RAM serves the display side. Host reads return one cycle after the request, marked by a valid strobe. Raster timing and pixel generation belong to other blocks.

Top module: `curs_host_port`

## Requirements
- R1: `host_sel` selects the port: 0 = pointer low byte, 1 = pointer high byte, 2 = register data, 3 = bitmap data. A write to port 0 or 1 loads `host_wdata[7:0]` into bits 7:0 or 15:8 of the pointer and leaves the other byte unchanged. A read of port 0 or 1 returns that pointer byte in `host_rdata[7:0]` and does not move the pointer.
- R2: Every read or write on port 2 or 3 advances the pointer by one after the access, and the pointer wraps from 0xFFFF to 0x0000.
- R3: Register addresses are 0x0 command, 0x1/0x2 cursor X low/high, 0x3/0x4 cursor Y low/high, 0x5/0x6 window X low/high, 0x7/0x8 window Y low/high, 0x9/0xA window width low/high, and 0xB/0xC window height low/high. Each coordinate output is {high[3:0], low[7:0]}.
- R4: Port 3 reads and writes whole 16-bit words of a 512 x 16 RAM at address pointer[8:0]. The read data and `host_rvalid` appear one cycle after the request.
- R5: A register write stores `host_wdata[7:0]`. A register read returns the byte in `host_rdata[7:0]` with `host_rdata[15:8]` zero.
- R6: A high coordinate register keeps only bits 3:0 of the written byte, and its bits 7:4 read back as zero.
- R7: The command byte drives `cursor_on` (bit 6), `xhair_on` (bit 5), `combine_or` (bit 4: 1 = OR, 0 = AND), `mux_mode` (bits 3:2) and `xhair_thick` (bits 1:0).
- R8: A register write at a pointer of 0x000D or above changes nothing except the pointer. A register read there returns zero.
- R9: A synchronous active-high reset clears the pointer, every register and `host_rvalid`.
- R10: `disp_data` returns the RAM word at `disp_addr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | One-cycle access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 2 | Port select (R1) |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data |
| host_rvalid | output | 1 | Read data valid |
| cursor_on | output | 1 | Cursor enable |
| xhair_on | output | 1 | Crosshair enable |
| combine_or | output | 1 | Cursor combine mode |
| mux_mode | output | 2 | Pixel multiplex mode |
| xhair_thick | output | 2 | Crosshair thickness code |
| curs_x | output | 12 | Cursor X |
| curs_y | output | 12 | Cursor Y |
| win_x | output | 12 | Window X |
| win_y | output | 12 | Window Y |
| win_w | output | 12 | Window width |
| win_h | output | 12 | Window height |
| disp_addr | input | 9 | Display-side bitmap address |
| disp_data | output | 16 | Display-side bitmap word |

## Verification
Assertions check on every cycle that the pointer loads and advances exactly as R1 and R2 require. They also check that out-of-range register writes leave every register unchanged, that read data is valid only one cycle after a read, and that reads outside the register space return zero. The stored bitmap contents, the mapping of each address to its display field, the masking of the high coordinate nibble and the pointer wrap through the ports all depend on the order of accesses. Only the bench's scenarios can show these.

// File: rtl/curs_pkg.sv
package curs_pkg;
  typedef enum logic [1:0] {
    SEL_PTR_LO = 2'd0,
    SEL_PTR_HI = 2'd1,
    SEL_REG    = 2'd2,
    SEL_MAP    = 2'd3
  } port_sel_e;

  typedef struct packed {
    logic       cursor_on;
    logic       xhair_on;
    logic       combine_or;
    logic [1:0] mux_mode;
    logic [1:0] thick;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [7:0] b);
    cmd_t c;
    c.cursor_on  = b[6];
    c.xhair_on   = b[5];
    c.combine_or = b[4];
    c.mux_mode   = b[3:2];
    c.thick      = b[1:0];
    return c;
  endfunction
endpackage

// File: rtl/curs_ptr.sv
module curs_ptr #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic          step,
  input  logic [7:0]    din,
  output logic [PW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)        ptr <= '0;
    else if (ld_lo) ptr[7:0] <= din;
    else if (ld_hi) ptr[PW-1:8] <= din[PW-9:0];
    else if (step)  ptr <= ptr + 1'b1;
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    step && !ld_lo && !ld_hi |=> ptr == $past(ptr) + 1'b1);
  assert_load_lo_R1: assert property (@(posedge clk) disable iff (rst)
    ld_lo |=> ptr[7:0] == $past(din) && ptr[PW-1:8] == $past(ptr[PW-1:8]));
  assert_load_hi_R1: assert property (@(posedge clk) disable iff (rst)
    ld_hi && !ld_lo |=> ptr[7:0] == $past(ptr[7:0]));
endmodule

// File: rtl/curs_regfile.sv
module curs_regfile #(
  parameter int PW   = 16,
  parameter int NREG = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [PW-1:0]   addr,
  input  logic [7:0]      din,
  output logic [7:0]      rd_byte,
  output logic [NREG*8-1:0] regs_flat
);
  logic [7:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam bit HIGH = (i != 0) && (i % 2 == 0);
    localparam logic [7:0] KEEP = HIGH ? 8'h0F : 8'hFF;
    always_ff @(posedge clk) begin
      if (rst) regs[i] <= '0;
      else if (we && addr == PW'(i)) regs[i] <= din & KEEP;
    end
    assign regs_flat[i*8 +: 8] = regs[i];
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NREG; i++)
      if (addr == PW'(i)) rd_byte = regs[i];
  end

  assert_ignore_high_addr_R8: assert property (@(posedge clk) disable iff (rst)
    we && addr >= PW'(NREG) |=> $stable(regs_flat));
  assert_cmd_write_R5: assert property (@(posedge clk) disable iff (rst)
    we && addr == '0 |=> regs_flat[7:0] == $past(din));
endmodule

// File: rtl/curs_ram.sv
module curs_ram #(
  parameter int AW = 9,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_din,
  output logic [DW-1:0] a_dout,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_dout
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_din;
    a_dout <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_dout <= mem[b_addr];
  end
endmodule

// File: rtl/curs_host_port.sv
module curs_host_port #(
  parameter int PW   = 16,
  parameter int DW   = 16,
  parameter int MAW  = 9,
  parameter int NREG = 13,
  parameter int CW   = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           host_req,
  input  logic           host_we,
  input  logic [1:0]     host_sel,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  output logic           host_rvalid,
  output logic           cursor_on,
  output logic           xhair_on,
  output logic           combine_or,
  output logic [1:0]     mux_mode,
  output logic [1:0]     xhair_thick,
  output logic [CW-1:0]  curs_x,
  output logic [CW-1:0]  curs_y,
  output logic [CW-1:0]  win_x,
  output logic [CW-1:0]  win_y,
  output logic [CW-1:0]  win_w,
  output logic [CW-1:0]  win_h,
  input  logic [MAW-1:0] disp_addr,
  output logic [DW-1:0]  disp_data
);
  import curs_pkg::*;

  localparam int HB = CW - 8;

  port_sel_e sel;
  logic [PW-1:0] ptr;
  logic [7:0] reg_byte, rbyte_q;
  logic [NREG*8-1:0] regs_flat;
  logic [DW-1:0] map_q;
  logic map_q_sel;
  logic wr, rd, data_acc;
  cmd_t cmd;

  assign sel      = port_sel_e'(host_sel);
  assign wr       = host_req && host_we;
  assign rd       = host_req && !host_we;
  assign data_acc = host_req && (sel == SEL_REG || sel == SEL_MAP);

  curs_ptr #(.PW(PW)) u_ptr (
    .clk(clk), .rst(rst),
    .ld_lo(wr && sel == SEL_PTR_LO),
    .ld_hi(wr && sel == SEL_PTR_HI),
    .step(data_acc),
    .din(host_wdata[7:0]),
    .ptr(ptr)
  );

  curs_regfile #(.PW(PW), .NREG(NREG)) u_regs (
    .clk(clk), .rst(rst),
    .we(wr && sel == SEL_REG),
    .addr(ptr),
    .din(host_wdata[7:0]),
    .rd_byte(reg_byte),
    .regs_flat(regs_flat)
  );

  curs_ram #(.AW(MAW), .DW(DW)) u_map (
    .clk(clk),
    .a_we(wr && sel == SEL_MAP),
    .a_addr(ptr[MAW-1:0]),
    .a_din(host_wdata),
    .a_dout(map_q),
    .b_addr(disp_addr),
    .b_dout(disp_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rvalid <= 1'b0;
      rbyte_q     <= '0;
      map_q_sel   <= 1'b0;
    end else begin
      host_rvalid <= rd;
      map_q_sel   <= (sel == SEL_MAP);
      unique case (sel)
        SEL_PTR_LO: rbyte_q <= ptr[7:0];
        SEL_PTR_HI: rbyte_q <= ptr[15:8];
        default:    rbyte_q <= reg_byte;
      endcase
    end
  end

  assign host_rdata = map_q_sel ? map_q : {{(DW-8){1'b0}}, rbyte_q};

  assign cmd         = decode_cmd(regs_flat[7:0]);
  assign cursor_on   = cmd.cursor_on;
  assign xhair_on    = cmd.xhair_on;
  assign combine_or  = cmd.combine_or;
  assign mux_mode    = cmd.mux_mode;
  assign xhair_thick = cmd.thick;

  assign curs_x = {regs_flat[2*8 +: HB],  regs_flat[1*8 +: 8]};
  assign curs_y = {regs_flat[4*8 +: HB],  regs_flat[3*8 +: 8]};
  assign win_x  = {regs_flat[6*8 +: HB],  regs_flat[5*8 +: 8]};
  assign win_y  = {regs_flat[8*8 +: HB],  regs_flat[7*8 +: 8]};
  assign win_w  = {regs_flat[10*8 +: HB], regs_flat[9*8 +: 8]};
  assign win_h  = {regs_flat[12*8 +: HB], regs_flat[11*8 +: 8]};

  assert_rvalid_latency_R4: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |-> $past(rd));
  assert_read_latency_R4: assert property (@(posedge clk) disable iff (rst)
    rd |=> host_rvalid);
  assert_out_of_range_read_R8: assert property (@(posedge clk) disable iff (rst)
    rd && sel == SEL_REG && ptr >= PW'(NREG) |=> host_rdata == '0);
  assert_byte_read_upper_R5: assert property (@(posedge clk) disable iff (rst)
    rd && sel != SEL_MAP |=> host_rdata[DW-1:8] == '0);
endmodule

// File: tb/curs_host_port_bench.sv
module curs_host_port_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [1:0] host_sel = 2'd0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic host_rvalid;
  logic cursor_on, xhair_on, combine_or;
  logic [1:0] mux_mode, xhair_thick;
  logic [11:0] curs_x, curs_y, win_x, win_y, win_w, win_h;
  logic [8:0] disp_addr = '0;
  logic [15:0] disp_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  curs_host_port u_curs_host_port (.*);

  // {sel[1:0], we, chk, wdata[15:0], expected[15:0]}
  localparam int NV = 17;
  localparam logic [35:0] VEC [NV] = '{
    {2'd0, 1'b1, 1'b0, 16'h0101, 16'h0000},
    {2'd1, 1'b1, 1'b0, 16'h0000, 16'h0000},
    {2'd2, 1'b1, 1'b0, 16'hABAB, 16'h0000},
    {2'd2, 1'b1, 1'b0, 16'hF5F5, 16'h0000},
    {2'd0, 1'b1, 1'b0, 16'h0101, 16'h0000},
    {2'd2, 1'b0, 1'b1, 16'h0000, 16'h00AB},
    {2'd2, 1'b0, 1'b1, 16'h0000, 16'h0005},
    {2'd0, 1'b0, 1'b1, 16'h0000, 16'h0003},
    {2'd0, 1'b1, 1'b0, 16'h1010, 16'h0000},
    {2'd1, 1'b1, 1'b0, 16'h0101, 16'h0000},
    {2'd3, 1'b1, 1'b0, 16'h1234, 16'h0000},
    {2'd3, 1'b1, 1'b0, 16'hBEEF, 16'h0000},
    {2'd0, 1'b1, 1'b0, 16'h1010, 16'h0000},
    {2'd3, 1'b0, 1'b1, 16'h0000, 16'h1234},
    {2'd3, 1'b0, 1'b1, 16'h0000, 16'hBEEF},
    {2'd0, 1'b0, 1'b1, 16'h0000, 16'h0012},
    {2'd1, 1'b0, 1'b1, 16'h0000, 16'h0001}
  };
  localparam string TAG [NV] = '{
    "R1", "R1", "R3", "R6", "R1", "R5", "R6", "R2", "R1",
    "R1", "R4", "R4", "R1", "R4", "R4", "R2", "R1"
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] s, input logic w, input logic [15:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = w; host_sel = s; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic read_check(input logic [1:0] s, input logic [15:0] exp, input string tag);
    access(s, 1'b0, 16'h0);
    check({tag, " rvalid"}, {31'd0, host_rvalid}, 32'd1);
    check(tag, {16'd0, host_rdata}, {16'd0, exp});
  endtask

  task automatic set_ptr(input logic [7:0] hi, input logic [7:0] lo);
    access(2'd0, 1'b1, {lo, lo});
    access(2'd1, 1'b1, {hi, hi});
  endtask

  task automatic wr_byte(input logic [7:0] b);
    access(2'd2, 1'b1, {b, b});
  endtask

  task automatic check_all_zero(input string tag);
    check(tag, {25'd0, cursor_on, xhair_on, combine_or, mux_mode, xhair_thick}, 32'd0);
    check(tag, {8'd0, curs_x, curs_y}, 32'd0);
    check(tag, {8'd0, win_x, win_y}, 32'd0);
    check(tag, {8'd0, win_w, win_h}, 32'd0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    @(negedge clk);
    check_all_zero("R9 reset outputs");
    check("R9 rvalid", {31'd0, host_rvalid}, 32'd0);
    read_check(2'd0, 16'h0000, "R9 pointer low");

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][35:34], VEC[i][33], VEC[i][31:16]);
      if (VEC[i][32]) begin
        check({TAG[i], " rvalid"}, {31'd0, host_rvalid}, 32'd1);
        check(TAG[i], {16'd0, host_rdata}, {16'd0, VEC[i][15:0]});
      end else begin
        check({TAG[i], " no rvalid on write"}, {31'd0, host_rvalid}, 32'd0);
      end
    end
    check("R3 R6 cursor X", {20'd0, curs_x}, 32'h5AB);

    // R7: command fields
    set_ptr(8'h00, 8'h00);
    wr_byte(8'h75);
    check("R7 fields", {25'd0, cursor_on, xhair_on, combine_or, mux_mode, xhair_thick},
          {25'd0, 1'b1, 1'b1, 1'b1, 2'b01, 2'b01});
    // R3: streaming Y and window
    set_ptr(8'h00, 8'h03);
    wr_byte(8'h34); wr_byte(8'hFF);
    check("R6 cursor Y high nibble", {20'd0, curs_y}, 32'hF34);
    wr_byte(8'h01); wr_byte(8'h0A); wr_byte(8'h02); wr_byte(8'h0B);
    wr_byte(8'h03); wr_byte(8'h0C); wr_byte(8'h04); wr_byte(8'h0D);
    check("R3 window X", {20'd0, win_x}, 32'hA01);
    check("R3 window Y", {20'd0, win_y}, 32'hB02);
    check("R3 window W", {20'd0, win_w}, 32'hC03);
    check("R3 window H", {20'd0, win_h}, 32'hD04);
    // R8: pointer now 0x0D, write ignored
    wr_byte(8'h99);
    check("R8 cmd unchanged", {25'd0, cursor_on, xhair_on, combine_or, mux_mode, xhair_thick},
          32'h75 & 32'h7F);
    check("R8 coords unchanged", {8'd0, curs_x, curs_y}, {8'd0, 12'h5AB, 12'hF34});
    check("R8 window unchanged", {8'd0, win_w, win_h}, {8'd0, 12'hC03, 12'hD04});
    read_check(2'd2, 16'h0000, "R8 read at 0x0E");
    set_ptr(8'h00, 8'h0D);
    read_check(2'd2, 16'h0000, "R8 read at 0x0D");
    set_ptr(8'h00, 8'h00);
    read_check(2'd2, 16'h0075, "R5 command readback");
    // R2: wrap
    set_ptr(8'hFF, 8'hFF);
    read_check(2'd0, 16'h00FF, "R1 pointer low FF");
    wr_byte(8'h55);
    read_check(2'd0, 16'h0000, "R2 wrap low");
    read_check(2'd1, 16'h0000, "R2 wrap high");
    // R4: bitmap uses pointer[8:0]
    set_ptr(8'hFE, 8'h10);
    access(2'd3, 1'b1, 16'hCAFE);
    set_ptr(8'h00, 8'h10);
    read_check(2'd3, 16'hCAFE, "R4 low nine bits");
    // R10: display port
    disp_addr = 9'h010;
    @(negedge clk);
    check("R10 display word 0x010", {16'd0, disp_data}, 32'hCAFE);
    disp_addr = 9'h111;
    @(negedge clk);
    check("R10 display word 0x111", {16'd0, disp_data}, 32'hBEEF);
    // R9: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    check_all_zero("R9 reset mid-run");
    read_check(2'd0, 16'h0000, "R9 pointer cleared");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule